// File: doc/BRIEF.md
# Down-Counting Reload Timer with Interrupt

This block is a timer peripheral with four word registers behind a simple synchronous write port and a combinational read port: a load word, a count word, a control word and a status word. Software writes a start value into the load word, which also seeds the counter. It then sets the run bit in the control word. The counter steps down by one on every tick of a prescaler. On the tick that finds it at zero it underflows, raises an interrupt, and starts again from either the load word or its all-ones maximum, as a control bit selects.

The interrupt has two behaviours. With the hold bit clear, every underflow gives a single-cycle pulse. With the hold bit set, the pending flag stays up until software writes zero to the status word. The counter keeps running meanwhile, but further underflows cannot raise a new interrupt. Reading the status word returns the load value.

Top module: `tmr_down`

## Requirements
- R1: After reset the load, count and control words all read zero and `irq_o` is low.
- R2: A write to offset 0x00 stores the low CNT_W bits of the data as the load value. Higher bits are dropped, and the maximum value is 2^CNT_W-1 (0x7FFFFF by default). The same write copies the value into the counter. Offset 0x00 reads back the load value.
- R3: Offset 0x04 reads the current count, and writes to 0x04 leave the count unchanged.
- R4: While control bit 7 (run) is set, the count drops by one per prescaler tick. While run is clear, the count holds its value.
- R5: Control bits 3:2 set the tick rate. Code 0 gives one tick per clock, code 1 one tick per 16 clocks, code 2 one tick per 256 clocks, and code 3 one tick per clock. From a load value N with run set, `irq_o` first rises (N+1)*D clocks after the control write, where D is the division.
- R6: Every write to the control word (0x08) restarts the prescaler. The next tick after the write therefore comes a full D clocks later.
- R7: With control bit 6 set, an underflow reloads the count from the load value, so later periods are also (N+1)*D clocks.
- R8: With control bit 6 clear, an underflow reloads the count to 2^CNT_W-1, so the next period is 2^CNT_W*D clocks.
- R9: With control bit 0 (hold) clear, each underflow gives a pulse on `irq_o` that is exactly one clock wide.
- R10: With hold set, the pending flag stays set after an underflow, and `irq_o` stays high as a level equal to it. Control bit 8 reads the flag. The counter keeps counting while the flag is set.
- R11: With hold set, writing zero to offset 0x0C clears the flag and drops `irq_o` on the next clock. Writing a nonzero value to 0x0C has no effect on the flag.
- R12: Offset 0x0C reads the current load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Byte offset of the word accessed (0x0, 0x4, 0x8, 0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt: a one-clock pulse with hold clear, a level with hold set |

## Verification
The bench builds the block with CNT_W = 8 and keeps the default prescaler shifts of 4 and 8. The reload-to-maximum period is then only 256 ticks, so with all four prescaler codes this case can be timed in full. The bench sweeps several small load values against every divide code with reload from the load word. For each pair it measures the clock count to the first and second interrupt and compares it with (N+1)*D. The hold, clear-on-zero, prescaler-restart and masking cases are timed the same way, to the exact clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [3:0] OFS_LOAD  = 4'h0;
    localparam logic [3:0] OFS_COUNT = 4'h4;
    localparam logic [3:0] OFS_CTRL  = 4'h8;
    localparam logic [3:0] OFS_STAT  = 4'hC;

    typedef enum logic [1:0] {
        DIV_ONE   = 2'd0,
        DIV_SLOW  = 2'd1,
        DIV_SLOWER = 2'd2,
        DIV_ALT   = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic     run;
        logic     reload;
        div_sel_e div;
        logic     hold;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  tmr_pkg::div_sel_e div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    import tmr_pkg::*;

    localparam int PW = (DIV_B_LOG > DIV_A_LOG) ? DIV_B_LOG : DIV_A_LOG;
    localparam logic [PW-1:0] LIM_A = PW'((1 << DIV_A_LOG) - 1);
    localparam logic [PW-1:0] LIM_B = PW'((1 << DIV_B_LOG) - 1);

    logic [PW-1:0] pcnt_d, pcnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        unique case (div_i)
            DIV_SLOW:   lim = LIM_A;
            DIV_SLOWER: lim = LIM_B;
            default:    lim = '0;
        endcase
        tick_o = run_i && (pcnt_q == lim);
        pcnt_d = pcnt_q + 1'b1;
        if (restart_i || !run_i || tick_o) begin
            pcnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_o || lim == '0));

    // R4
    stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             reload_i,
    input  logic             hold_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     uflow;

    always_comb begin
        st_d  = st_q;
        uflow = tick_i && (st_q.count == '0);
        if (load_wr_i) begin
            st_d.count = load_val_i;
        end else if (tick_i) begin
            if (st_q.count == '0) st_d.count = reload_i ? load_val_i : MAXV;
            else                  st_d.count = st_q.count - 1'b1;
        end
        st_d.flag = uflow || (hold_i && st_q.flag && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign flag_o  = st_q.flag;

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> st_q.count == $past(load_val_i));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_wr_i) |=> $stable(st_q.count));

    // R7
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && reload_i && !load_wr_i) |=> st_q.count == $past(load_val_i));

    // R8
    reload_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !reload_i && !load_wr_i) |=> st_q.count == MAXV);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !uflow) |=> !st_q.flag);

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && st_q.flag && !clr_i) |=> st_q.flag);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && clr_i && !uflow) |=> !st_q.flag);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_i,
    output tmr_pkg::ctrl_t   ctrl_o,
    output logic [CNT_W-1:0] load_o,
    output logic             load_wr_o,
    output logic             ctrl_wr_o,
    output logic             clr_o,
    output logic [31:0]      bus_rdata
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] load;
        ctrl_t            ctrl;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    always_comb begin
        rg_d      = rg_q;
        load_wr_o = bus_wr && (bus_addr == OFS_LOAD);
        ctrl_wr_o = bus_wr && (bus_addr == OFS_CTRL);
        clr_o     = bus_wr && (bus_addr == OFS_STAT) && (bus_wdata == 32'd0);
        if (load_wr_o) begin
            rg_d.load = bus_wdata[CNT_W-1:0];
        end
        if (ctrl_wr_o) begin
            rg_d.ctrl.hold   = bus_wdata[0];
            rg_d.ctrl.div    = div_sel_e'(bus_wdata[3:2]);
            rg_d.ctrl.reload = bus_wdata[6];
            rg_d.ctrl.run    = bus_wdata[7];
        end
        unique case (bus_addr)
            OFS_LOAD:  bus_rdata = 32'(rg_q.load);
            OFS_COUNT: bus_rdata = 32'(count_i);
            OFS_CTRL:  bus_rdata = {23'd0, flag_i, rg_q.ctrl.run, rg_q.ctrl.reload,
                                    2'b00, rg_q.ctrl.div, 1'b0, rg_q.ctrl.hold};
            OFS_STAT:  bus_rdata = 32'(rg_q.load);
            default:   bus_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign ctrl_o = rg_q.ctrl;
    assign load_o = rg_q.load;

    // R12
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STAT) |-> bus_rdata == 32'(load_o));

    // R10
    flag_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> bus_rdata[8] == flag_i);

endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
    parameter int CNT_W     = 23,
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    import tmr_pkg::*;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             load_wr, ctrl_wr, clr, tick, flag;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count_i(count), .flag_i(flag), .ctrl_o(ctrl),
        .load_o(load_val), .load_wr_o(load_wr), .ctrl_wr_o(ctrl_wr),
        .clr_o(clr), .bus_rdata(bus_rdata)
    );

    tmr_prescale #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .div_i(ctrl.div),
        .restart_i(ctrl_wr), .tick_o(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_wr_i(load_wr),
        .load_val_i(bus_wdata[CNT_W-1:0] & {CNT_W{load_wr}} | load_val & {CNT_W{!load_wr}}),
        .reload_i(ctrl.reload), .hold_i(ctrl.hold), .clr_i(clr),
        .count_o(count), .flag_o(flag)
    );

    assign irq_o = flag;

endmodule

// File: tb/tb_tmr_down.sv
module tb_tmr_down;
    localparam int CW = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_down #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(negedge clk);
            n++;
            if (irq_o) break;
        end
    endtask

    task automatic stop_all();
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0);
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int divof(input int code);
        return (code == 1) ? 16 : (code == 2) ? 256 : 1;
    endfunction

    initial begin
        logic [31:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1 load", v, 0);
        rd(4'h4, v); chk("R1 count", v, 0);
        rd(4'h8, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", irq_o, 0);

        // R2 masking and copy into counter
        wr(4'h0, 32'hFFFF_FF5A);
        rd(4'h0, v); chk("R2 load masked", v, 32'h5A);
        rd(4'h4, v); chk("R2 count copy", v, 32'h5A);
        // R12 status reads load
        rd(4'hC, v); chk("R12 status read", v, 32'h5A);

        // R3 count write ignored
        wr(4'h4, 32'h11);
        rd(4'h4, v); chk("R3 count unchanged", v, 32'h5A);

        // R4 stopped count holds
        repeat (20) @(negedge clk);
        rd(4'h4, v); chk("R4 stopped hold", v, 32'h5A);

        // R4 running decrements per tick (div16)
        wr(4'h0, 32'd20);
        wr(4'h8, 32'h0000_00C4);
        repeat (48) @(negedge clk);
        rd(4'h4, v); chk("R4 three ticks", v, 17);
        stop_all();

        // R5 R7 sweep: load values x divide codes, reload from load
        for (int code = 0; code < 4; code++) begin
            for (int k = 0; k < 4; k++) begin
                int nv;
                nv = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : 9;
                wr(4'h0, nv);
                wr(4'h8, 32'h0000_00C0 | (code << 2));
                wait_irq(4000, n);
                chk("R5 first period", n, (nv + 1) * divof(code));
                rd(4'h4, v); chk("R7 count reloaded", v, nv);
                @(negedge clk);
                chk("R9 one-cycle pulse", irq_o, 0);
                wait_irq(4000, n);
                chk("R7 second period", n, (nv + 1) * divof(code) - 1);
                stop_all();
            end
        end

        // R5 zero load with div16
        wr(4'h0, 32'd0);
        wr(4'h8, 32'h0000_00C4);
        wait_irq(100, n);
        chk("R5 zero load period", n, 16);
        stop_all();

        // R8 reload to maximum
        wr(4'h0, 32'd2);
        wr(4'h8, 32'h0000_0080);
        wait_irq(1000, n);
        chk("R8 first period", n, 3);
        rd(4'h4, v); chk("R8 count at max", v, 255);
        wait_irq(1000, n);
        chk("R8 max period", n, 256);
        stop_all();

        // R6 ctrl rewrite restarts prescaler
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h0000_00C4);
        repeat (9) @(negedge clk);
        wr(4'h8, 32'h0000_00C4);
        rd(4'h4, v); chk("R6 no tick yet", v, 3);
        wait_irq(1000, n);
        chk("R6 restart period", n, 64);
        stop_all();

        // R10 hold: sticky level, counter keeps running
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h0000_00C1);
        wait_irq(100, n);
        chk("R10 hold period", n, 4);
        rd(4'h4, v);
        repeat (9) @(negedge clk);
        chk("R10 irq level held", irq_o, 1);
        rd(4'h8, v2); chk("R10 ctrl bit8", v2[8], 1);
        rd(4'h4, v2); chk("R10 counter running", (v2 == v) ? 1 : 0, 0);
        // R11 nonzero status write ignored
        wr(4'hC, 32'd5);
        chk("R11 nonzero no clear", irq_o, 1);
        // R11 zero clears
        wr(4'hC, 32'd0);
        chk("R11 zero clears", irq_o, 0);
        rd(4'h8, v2); chk("R11 ctrl bit8 clear", v2[8], 0);
        rd(4'hC, v2); chk("R12 status read again", v2, 3);
        stop_all();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule